// File: doc/BRIEF.md
# Synchronous SRAM Burst Address Sequencer

This block produces the internal word address for a pipelined synchronous SRAM during short bursts. A burst begins when either of two active-low start strobes is sampled low at a rising clock edge: one strobe belongs to a processor port, the other to a cache-controller port. On that edge the whole external address is captured and the beat index returns to zero. On later edges, while the active-low advance input is low, the beat index steps forward. The captured address's two lowest bits combine with the beat index to form the low bits of the output address. All higher bits keep the captured value.

A static order-select input picks how the low bits move. With the select low, the sequence counts upward and wraps inside the aligned group of four words. With the select high, the sequence is the start bits XORed with the beat index. High is the intended default for a board that leaves the input unconnected. The outputs feed the array decoder and any logic that must know which beat of a burst is in progress.

Top module: `burst_addr_gen`

## Requirements
- R1: While the active-low reset is asserted, `addr_out` and `beat` are both zero.
- R2: A low level on `strobe_cpu_n` or on `strobe_ctl_n` at a rising edge loads `addr_in`. After that edge, `beat` is 0 and `addr_out` equals the loaded address.
- R3: A strobe wins over advance. When a strobe is low and `advance_n` is also low at an edge, the block reloads and sets `beat` to 0. It does not step. This holds in the middle of a burst too.
- R4: When both strobes are high and `advance_n` is low at an edge, `beat` becomes the old value plus one, modulo 4.
- R5: When both strobes are high and `advance_n` is high at an edge, `beat` and `addr_out` keep their values.
- R6: With `order_sel` = 0 (linear), the two low bits of `addr_out` equal (start + beat) mod 4. Here start is bits [1:0] of the loaded address.
- R7: With `order_sel` = 1 (interleaved), the two low bits of `addr_out` equal start XOR beat. For example, start 1 gives the sequence 1, 0, 3, 2.
- R8: Between loads, bits [ADDR_W-1:2] of `addr_out` keep the loaded value in both orders.
- R9: An advance at beat 3 returns `beat` to 0 and the low address bits to the start bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External address captured when a burst starts |
| strobe_cpu_n | input | 1 | Processor burst-start strobe, active low |
| strobe_ctl_n | input | 1 | Cache-controller burst-start strobe, active low |
| advance_n | input | 1 | Step to the next beat, active low |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_out | output | ADDR_W | Current internal word address |
| beat | output | BEAT_W | Index of the current beat within the burst |

## Verification
The bench builds the block with ADDR_W = 6 and BEAT_W = 2. This leaves sixteen upper-address values and four start offsets. Every full address is loaded through each strobe in both orders. Each burst then walks past beat 3 with a hold inserted, so every start/beat pair of both orders, the wrap and the hold are all reached. Reloads in the middle of a burst, with advance held low, cover strobe priority through each strobe and through both strobes together.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } burst_cmd_e;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_pkg::*;
(
    input  logic       strobe_cpu_n,
    input  logic       strobe_ctl_n,
    input  logic       advance_n,
    output burst_cmd_e cmd
);

    // Either start strobe outranks the advance request.
    always_comb begin
        if (!strobe_cpu_n || !strobe_ctl_n) begin
            cmd = CMD_LOAD;
        end else if (!advance_n) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              interleave,
    output logic [BEAT_W-1:0] low
);

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    // Linear: modular sum wraps inside the aligned group.
    assign lin_low = start + beat;

    // Interleaved: each bit lane flips independently.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_lane
        assign ilv_low[i] = start[i] ^ beat[i];
    end

    assign low = interleave ? ilv_low : lin_low;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              advance_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BEAT_W-1:0] beat
);

    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] beat;
    } state_t;

    state_t            st_d;
    state_t            st_q;
    burst_cmd_e        cmd;
    logic [BEAT_W-1:0] low_bits;

    burst_cmd_decode u_dec (
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .advance_n    (advance_n),
        .cmd          (cmd)
    );

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_LOAD: begin
                st_d.base = addr_in;
                st_d.beat = '0;
            end
            CMD_STEP: begin
                st_d.beat = st_q.beat + BEAT_ONE;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .start      (st_q.base[BEAT_W-1:0]),
        .beat       (st_q.beat),
        .interleave (order_sel),
        .low        (low_bits)
    );

    assign addr_out = {st_q.base[ADDR_W-1:BEAT_W], low_bits};
    assign beat     = st_q.beat;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strobe_cpu_n,
    input logic              strobe_ctl_n,
    input logic              advance_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_out,
    input logic [BEAT_W-1:0] beat
);

    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    logic              any_strobe;
    logic [BEAT_W-1:0] beat_inc;
    logic [BEAT_W-1:0] lin_key;
    logic [BEAT_W-1:0] ilv_key;

    assign any_strobe = !strobe_cpu_n || !strobe_ctl_n;
    assign beat_inc   = beat + BEAT_ONE;
    // The start offset recovered from the output; it must not change within a burst.
    assign lin_key    = addr_out[BEAT_W-1:0] - beat;
    assign ilv_key    = addr_out[BEAT_W-1:0] ^ beat;

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> (beat == '0) && (addr_out == $past(addr_in)));

    assert_strobe_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (any_strobe && !advance_n) |=> (beat == '0));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_strobe && !advance_n) |=> (beat == $past(beat_inc)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_strobe && advance_n) |=> $stable(beat));

    assert_linear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!order_sel && !$past(order_sel) && !$past(any_strobe)) |-> $stable(lin_key));

    assert_interleave_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (order_sel && $past(order_sel) && !$past(any_strobe)) |-> $stable(ilv_key));

    assert_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_strobe |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_strobe && !advance_n && (beat == '1)) |=> (beat == '0));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_in      (addr_in),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .advance_n    (advance_n),
    .order_sel    (order_sel),
    .addr_out     (addr_out),
    .beat         (beat)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

    localparam int ADDR_W = 6;
    localparam int BEAT_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              strobe_cpu_n = 1'b1;
    logic              strobe_ctl_n = 1'b1;
    logic              advance_n = 1'b1;
    logic              order_sel = 1'b1;
    logic [ADDR_W-1:0] addr_out;
    logic [BEAT_W-1:0] beat;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int m_base = 0;
    int m_cnt  = 0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_burst_addr_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_in      (addr_in),
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .advance_n    (advance_n),
        .order_sel    (order_sel),
        .addr_out     (addr_out),
        .beat         (beat)
    );

    function automatic int exp_addr();
        int start = m_base % 4;
        int low;
        if (order_sel) low = start ^ m_cnt;
        else           low = (start + m_cnt) % 4;
        return (m_base / 4) * 4 + low;
    endfunction

    task automatic check(input string tag);
        n_cmp++;
        if (int'(addr_out) != exp_addr() || int'(beat) != m_cnt) begin
            n_bad++;
            $display("FAIL %s: addr_out=%0d beat=%0d expected addr_out=%0d beat=%0d",
                     tag, addr_out, beat, exp_addr(), m_cnt);
        end
    endtask

    task automatic step(input logic s_cpu, input logic s_ctl, input logic adv,
                        input int a, input string tag);
        @(negedge clk);
        strobe_cpu_n = s_cpu;
        strobe_ctl_n = s_ctl;
        advance_n    = adv;
        addr_in      = ADDR_W'(a);
        @(posedge clk);
        if (!s_cpu || !s_ctl) begin
            m_base = a;
            m_cnt  = 0;
        end else if (!adv) begin
            m_cnt = (m_cnt + 1) % 4;
        end
        #1;
        check(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #22;
        check("R1");
        @(negedge clk);
        rst_n = 1'b1;

        for (int mode = 0; mode < 2; mode++) begin
            for (int via = 0; via < 2; via++) begin
                for (int a = 0; a < 64; a++) begin
                    string ord_tag;
                    @(negedge clk);
                    order_sel = mode[0];
                    ord_tag = (mode == 1) ? "R4/R7" : "R4/R6";
                    step(via == 1, via == 0, 1'b1, a, "R2");
                    step(1'b1, 1'b1, 1'b0, a, ord_tag);
                    step(1'b1, 1'b1, 1'b0, a, ord_tag);
                    step(1'b1, 1'b1, 1'b1, a, "R5");
                    step(1'b1, 1'b1, 1'b0, a, ord_tag);
                    step(1'b1, 1'b1, 1'b0, a, "R9");
                    step(1'b1, 1'b1, 1'b0, a, ord_tag);
                    n_cmp++;
                    if (int'(addr_out) / 4 != a / 4) begin
                        n_bad++;
                        $display("FAIL R8: upper=%0d expected=%0d", addr_out / 4, a / 4);
                    end
                end
            end
        end

        // R3: reload in the middle of a burst with advance held low
        for (int mode = 0; mode < 2; mode++) begin
            @(negedge clk);
            order_sel = mode[0];
            step(1'b0, 1'b1, 1'b1, 13, "R2");
            step(1'b1, 1'b1, 1'b0, 13, "R4");
            step(1'b1, 1'b1, 1'b0, 13, "R4");
            step(1'b0, 1'b1, 1'b0, 42, "R3");
            step(1'b1, 1'b1, 1'b0, 42, "R4");
            step(1'b1, 1'b0, 1'b0, 7, "R3");
            step(1'b1, 1'b1, 1'b0, 7, "R4");
            step(1'b0, 1'b0, 1'b0, 58, "R3");
            step(1'b1, 1'b1, 1'b1, 58, "R5");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule